// File: doc/BRIEF.md
# Latched Hexadecimal Seven-Segment Decoder

This block turns a 4-bit value into the seven active-low segment drives of a single display digit. It shows the sixteen codes as the digits 0 to 9 and the letters A, b, C, d, E, F. A data latch sits in front of the decoder. While the capture control is low, the display follows the live input. While the control is high, the display keeps the value that was last stored, whatever happens on the data lines.

Several digits can be chained to suppress leading or trailing zeros. Each stage receives a ripple-blanking request from its neighbour. The stage blanks itself only when the value it shows is zero, and it passes the request on through its own ripple output. A separate force-blank input turns every segment off, whatever the data, latch or ripple state. The open-collector pin of a discrete part is split here into this force input and the ripple output.

The latch is a clocked register. On every rising clock edge with the capture control low, it stores the input. Reset clears it to zero.

Top module: `hexSegLatch`

## Requirements
- R1: Segment output bit 0 drives segment a, bit 1 drives b, and so on up to bit 6, which drives g. A 0 lights the segment and a 1 leaves it dark.
- R2: The digits light these segments: 0=abcdef, 1=bc, 2=abdeg, 3=abcdg, 4=bcfg, 5=acdfg, 6=acdefg, 7=abc, 8=abcdefg, 9=abcdfg.
- R3: The codes 10 to 15 light these segments: 10=abcefg (A), 11=cdefg (b), 12=adef (C), 13=bcdeg (d), 14=adefg (E), 15=aefg (F).
- R4: While captureN is low, the segments decode the live dataIn in the same cycle, without waiting for a clock edge.
- R5: While captureN is high, the segments show the value stored at the last rising clock edge on which captureN was low, and changes on dataIn have no effect. After reset the stored value is 0.
- R6: When rippleInN is low and the shown value is 0, all seven segment outputs are 1. A shown value other than 0 is displayed normally.
- R7: rippleOutN is 0 exactly when rippleInN is 0 and the shown value is 0. Otherwise it is 1.
- R8: When blankForceN is low, all segment outputs are 1, whatever the data, captureN and rippleInN. It does not change rippleOutN, and it does not change the stored value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the data latch |
| rstN | input | 1 | Asynchronous reset, active low; clears the stored value |
| dataIn | input | 4 | Value to be shown |
| captureN | input | 1 | Low: transparent, and the value is stored on each clock. High: hold |
| rippleInN | input | 1 | Zero-blanking request from the neighbouring stage, active low |
| blankForceN | input | 1 | Blanks every segment, active low; takes priority over all other inputs |
| rippleOutN | output | 1 | Low when this stage blanks a zero on request |
| segN | output | 7 | Segment drives a..g on bits 0..6, active low |

## Verification
The hardest case to reach is a display in hold that stores a zero while the live data lines carry a non-zero value, with a ripple request arriving at that point. Blanking must follow the stored zero and not the data lines. The stimulus first loads 0 with captureN low, then raises captureN, drives a non-zero code on dataIn, and only then pulls rippleInN low. The same state is then repeated with the force input asserted, to show that the force input blanks the display without disturbing the ripple output. A long run with random stimulus, compared against the model on every cycle, then crosses latch transitions with both blanking inputs.

// File: rtl/hexSegPkg.sv
package hexSegPkg;
  localparam int HEX_W = 4;
  localparam int SEG_W = 7;

  typedef struct packed {
    logic passLive;
    logic loadEn;
    logic blankAll;
  } segStrobes_t;

  // lit pattern, bit 0 = segment a ... bit 6 = segment g, 1 = lit
  function automatic logic [SEG_W-1:0] glyphLit(input logic [HEX_W-1:0] code);
    logic [SEG_W-1:0] lit;
    case (code)
      4'h0: lit = 7'b0111111;
      4'h1: lit = 7'b0000110;
      4'h2: lit = 7'b1011011;
      4'h3: lit = 7'b1001111;
      4'h4: lit = 7'b1100110;
      4'h5: lit = 7'b1101101;
      4'h6: lit = 7'b1111101;
      4'h7: lit = 7'b0000111;
      4'h8: lit = 7'b1111111;
      4'h9: lit = 7'b1101111;
      4'hA: lit = 7'b1110111;
      4'hB: lit = 7'b1111100;
      4'hC: lit = 7'b0111001;
      4'hD: lit = 7'b1011110;
      4'hE: lit = 7'b1111001;
      default: lit = 7'b1110001;
    endcase
    return lit;
  endfunction
endpackage

// File: rtl/hexSegCtrl.sv
module hexSegCtrl
  import hexSegPkg::*;
(
  input  logic        captureN,
  input  logic        rippleInN,
  input  logic        blankForceN,
  input  logic        shownZero,
  output segStrobes_t strobes,
  output logic        rippleOutN
);
  logic rippleBlank;

  always_comb begin
    rippleBlank      = !rippleInN && shownZero;
    strobes.passLive = !captureN;
    strobes.loadEn   = !captureN;
    strobes.blankAll = !blankForceN || rippleBlank;
    rippleOutN       = !rippleBlank;
  end
endmodule

// File: rtl/hexSegPath.sv
module hexSegPath
  import hexSegPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [HEX_W-1:0] dataIn,
  input  segStrobes_t      strobes,
  output logic             shownZero,
  output logic [SEG_W-1:0] segN
);
  logic [HEX_W-1:0] storedVal;
  logic [HEX_W-1:0] shownVal;
  logic [SEG_W-1:0] litPattern;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               storedVal <= '0;
    else if (strobes.loadEn) storedVal <= dataIn;
  end

  always_comb begin
    shownVal   = strobes.passLive ? dataIn : storedVal;
    shownZero  = (shownVal == '0);
    litPattern = glyphLit(shownVal);
    segN       = strobes.blankAll ? '1 : ~litPattern;
  end
endmodule

// File: rtl/hexSegLatch.sv
module hexSegLatch
  import hexSegPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [HEX_W-1:0] dataIn,
  input  logic             captureN,
  input  logic             rippleInN,
  input  logic             blankForceN,
  output logic             rippleOutN,
  output logic [SEG_W-1:0] segN
);
  segStrobes_t strobes;
  logic        shownZero;

  hexSegCtrl i_ctrl (
    .captureN   (captureN),
    .rippleInN  (rippleInN),
    .blankForceN(blankForceN),
    .shownZero  (shownZero),
    .strobes    (strobes),
    .rippleOutN (rippleOutN)
  );

  hexSegPath i_path (
    .clk      (clk),
    .rstN     (rstN),
    .dataIn   (dataIn),
    .strobes  (strobes),
    .shownZero(shownZero),
    .segN     (segN)
  );
endmodule

// File: rtl/hexSegLatchChk.sv
module hexSegLatchChk
  import hexSegPkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic [HEX_W-1:0] dataIn,
  input logic             captureN,
  input logic             rippleInN,
  input logic             blankForceN,
  input logic             rippleOutN,
  input logic [SEG_W-1:0] segN
);
  // R8: the force input darkens every segment
  a_r8_force_dark: assert property (@(posedge clk) disable iff (!rstN)
    !blankForceN |-> segN == '1);

  // R6, R7: a stage that passes on the ripple request is dark
  a_r7_ripple_dark: assert property (@(posedge clk) disable iff (!rstN)
    !rippleOutN |-> segN == '1);

  // R7: with no request coming in, none goes out
  a_r7_no_request: assert property (@(posedge clk) disable iff (!rstN)
    rippleInN |-> rippleOutN);

  // R4: a transparent, unblanked stage always lights something
  a_r4_lit_when_live: assert property (@(posedge clk) disable iff (!rstN)
    (!captureN && rippleInN && blankForceN) |-> segN != '1);

  // R5: in hold with steady blanking inputs, the segments do not move
  a_r5_hold_stable: assert property (@(posedge clk) disable iff (!rstN)
    (captureN && $past(captureN) && $stable(rippleInN) && $stable(blankForceN))
      |-> $stable(segN));
endmodule

bind hexSegLatch hexSegLatchChk i_chk (
  .clk(clk), .rstN(rstN), .dataIn(dataIn), .captureN(captureN),
  .rippleInN(rippleInN), .blankForceN(blankForceN),
  .rippleOutN(rippleOutN), .segN(segN)
);

// File: tb/test_hexSegLatch.sv
module test_hexSegLatch;
  localparam int CLK_PERIOD = 10;

  logic       clk = 0;
  logic       rstN = 0;
  logic [3:0] dataIn = 0;
  logic       captureN = 1;
  logic       rippleInN = 1;
  logic       blankForceN = 1;
  logic       rippleOutN;
  logic [6:0] segN;

  int checks = 0;
  int errors = 0;
  int refStored = 0;
  bit done = 0;

  hexSegLatch i_hexSegLatch (
    .clk(clk), .rstN(rstN), .dataIn(dataIn), .captureN(captureN),
    .rippleInN(rippleInN), .blankForceN(blankForceN),
    .rippleOutN(rippleOutN), .segN(segN)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // segment letters a..g from the requirement text, mapped to bits 0..6
  function automatic logic [6:0] fromLetters(input string s);
    logic [6:0] v = 0;
    for (int i = 0; i < s.len(); i++) v[s[i] - "a"] = 1'b1;
    return v;
  endfunction

  function automatic logic [6:0] refLit(input int code);
    string names[16] = '{"abcdef", "bc", "abdeg", "abcdg", "bcfg", "acdfg",
                         "acdefg", "abc", "abcdefg", "abcdfg", "abcefg",
                         "cdefg", "adef", "bcdeg", "adefg", "aefg"};
    return fromLetters(names[code]);
  endfunction

  task automatic checkOutputs(input string req);
    int shown = captureN ? refStored : int'(dataIn);
    bit rippleHit = !rippleInN && shown == 0;
    logic [6:0] expSeg = (!blankForceN || rippleHit) ? 7'h7F : ~refLit(shown);
    logic expRipple = !rippleHit;
    checks++;
    if (segN !== expSeg || rippleOutN !== expRipple) begin
      errors++;
      $display("FAIL %s: segN=%b rippleOutN=%b expected segN=%b rippleOutN=%b",
               req, segN, rippleOutN, expSeg, expRipple);
    end
  endtask

  // apply inputs after a falling edge, check, then let the rising edge update the model
  task automatic step(input logic [3:0] d, input logic cap, input logic rin,
                      input logic bf, input string req);
    @(negedge clk);
    dataIn = d; captureN = cap; rippleInN = rin; blankForceN = bf;
    #(CLK_PERIOD/4);
    checkOutputs(req);
    @(posedge clk);
    if (!captureN) refStored = int'(dataIn);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #(CLK_PERIOD/4);
    checkOutputs("R5 reset value zero shown");
    @(negedge clk);
    rstN = 1;

    // R1 R2 R3 R4: every code transparent
    for (int c = 0; c < 16; c++)
      step(4'(c), 1'b0, 1'b1, 1'b1, c < 10 ? "R2 R1 R4 digit" : "R3 R1 R4 letter");

    // R5: store 5, then move the data lines while holding
    step(4'h5, 1'b0, 1'b1, 1'b1, "R4 load 5");
    step(4'hA, 1'b1, 1'b1, 1'b1, "R5 hold ignores data A");
    step(4'h3, 1'b1, 1'b1, 1'b1, "R5 hold ignores data 3");

    // R6 R7: stored zero with non-zero live data, then ripple request
    step(4'h0, 1'b0, 1'b1, 1'b1, "R4 load 0");
    step(4'h9, 1'b1, 1'b1, 1'b1, "R5 hold shows 0");
    step(4'h9, 1'b1, 1'b0, 1'b1, "R6 R7 stored zero blanks");
    step(4'h9, 1'b1, 1'b0, 1'b0, "R8 force with ripple active");
    step(4'h0, 1'b0, 1'b0, 1'b1, "R6 R7 live zero blanks");
    step(4'h4, 1'b0, 1'b0, 1'b1, "R6 R7 nonzero not blanked");
    step(4'h8, 1'b1, 1'b0, 1'b1, "R6 R7 stored 4 not blanked");

    // R8: force does not alter the stored value
    step(4'h1, 1'b1, 1'b1, 1'b0, "R8 force in hold");
    step(4'h2, 1'b0, 1'b1, 1'b0, "R8 force while transparent");
    step(4'h7, 1'b1, 1'b1, 1'b1, "R8 store kept under force");

    // random crossing of all controls
    for (int n = 0; n < 400; n++)
      step(4'($urandom_range(0, 15)), 1'($urandom_range(0, 1)),
           1'($urandom_range(0, 1)), $urandom_range(0, 5) != 0,
           "R4 R5 R6 R7 R8 random");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule